// File: doc/BRIEF.md
# Peripheral-Status Interrupt Collector

This block sits in a host-side parallel-port bridge and gathers seven interrupt conditions into one pending output. Four of them come from the lines that the attached peripheral drives: a rising acknowledge strobe, a fault line that is watched only in extended-capability mode, any change on those lines, and a detach condition. The remaining three come from the bridge core: an enhanced-parallel-port handshake timeout pulse, inbound data being available, and the outbound pipeline draining empty. Each condition has its own enable. The acknowledge condition is enabled by a 1 on its enable bit. The other six are enabled by a 0 on their mask bit.

Every enabled condition is held in a sticky pending bit, and the interrupt output is the OR of those bits. A one-cycle read strobe captures a status snapshot and then clears every pending bit. A condition that arrives in the same cycle as the read survives the clear. Peripheral lines pass through two-flop synchronizers before any edge is detected.

The detach condition has two causes: a falling edge on the peripheral logic-high line, or a one-second timeout. The timeout is run by a small state machine. The machine waits in IDLE. It moves to COUNT on the ARM transition, when logic-high is low and the other five peripheral lines are all high. It falls back to IDLE on BREAK when that qualifier drops. It moves to DONE on EXPIRE after SEC_CYCLES cycles, raising the condition once. It returns to IDLE on RELEASE when the qualifier drops.

Top module: `pp_irq_gather`

## Requirements
- R1: After reset, every pending bit (`pend`), `irq` and the snapshot word `snap` are 0.
- R2: With `ctl_ack_en`=1, a low-to-high transition of `pin_ack_n` sets `pend[0]`. With `ctl_ack_en`=0 it does not.
- R3: `ctl_mask` bits suppress conditions when 1 and enable them when 0. The mapping is: mask[0] to `pend[1]` (handshake timeout), mask[1] to `pend[2]` (fault), mask[2] to `pend[3]` (inbound data), mask[3] to `pend[4]` (outbound empty), mask[4] to `pend[5]` (line change), mask[5] to `pend[6]` (detach).
- R4: `pend[2]` is set only while `ecp_mode`=1, on a falling edge of `pin_fault_n` or in any cycle in which `pin_fault_n` is low.
- R5: `pend[3]` is set in every cycle in which `bin_avail` is 1. Snapshot bit 4 reports inbound empty, which is the inverse of `bin_avail`.
- R6: `pend[4]` is set only on a 0-to-1 transition of `bout_empty`. Snapshot bit 5 reports the `bout_empty` level.
- R7: `pend[5]` is set when any of the six peripheral lines changes state. The six lines are `pin_ack_n`, `pin_busy`, `pin_fault_n`, `pin_perr`, `pin_sel` and `pin_logic_hi`.
- R8: A falling edge of `pin_logic_hi` sets `pend[6]`.
- R9: `pend[6]` is also set once when `pin_logic_hi` has been low and the other five lines high for SEC_CYCLES consecutive cycles. Any break in that condition restarts the count. The condition does not fire again until it has dropped.
- R10: In the cycle after `rd_stb`=1, `snap` holds {2'b0, bout_empty, ~bin_avail, pend[3:0]} as it stood in the strobe cycle. All pending bits are cleared except those set by a condition in that same cycle.
- R11: `irq` is 1 exactly when some pending bit whose condition is currently enabled is set. It drops once a read has cleared them.
- R12: A pending bit stays set until a read, whatever its source does meanwhile.
- R13: A one-cycle `epp_timeout` pulse sets `pend[1]` when unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_ack_n | input | 1 | Peripheral acknowledge line (asynchronous) |
| pin_busy | input | 1 | Peripheral busy line (asynchronous) |
| pin_fault_n | input | 1 | Peripheral fault line, active low (asynchronous) |
| pin_perr | input | 1 | Peripheral paper-error line (asynchronous) |
| pin_sel | input | 1 | Peripheral select line (asynchronous) |
| pin_logic_hi | input | 1 | Peripheral logic-high presence line (asynchronous) |
| ecp_mode | input | 1 | Port is in extended-capability mode |
| epp_timeout | input | 1 | One-cycle handshake-timeout pulse |
| bin_avail | input | 1 | Inbound data is available for the host |
| bout_empty | input | 1 | Outbound pipeline is completely empty |
| ctl_ack_en | input | 1 | Acknowledge condition enable (1 = on) |
| ctl_mask | input | 6 | Masks for the other six conditions (1 = off) |
| rd_stb | input | 1 | Status read strobe, one cycle |
| pend | output | 7 | Latched pending conditions |
| irq | output | 1 | Interrupt pending |
| snap | output | 8 | Status word captured by the last read |

## Verification
The assertions assume that reset is held over at least one clock edge and that every input is at a defined level from then on. They also assume that the enables and masks seen in one cycle are the ones that gate the latch at the next edge. The bench changes inputs only on the falling clock edge and holds the peripheral lines at their idle levels through reset, so the synchronizers start without false edges. It raises one condition at a time, except in the sweep over every enable and mask combination, where each source fires in its own cycle. The bench waits out the synchronizer delay before every comparison.

// File: rtl/pp_irq_pkg.sv
package pp_irq_pkg;

    localparam int NUM_PINS = 6;
    localparam int NUM_SRC  = 7;
    localparam int SNAP_W   = 8;

    // peripheral line positions inside the pin vector
    localparam int PIN_ACK   = 0;
    localparam int PIN_BUSY  = 1;
    localparam int PIN_FAULT = 2;
    localparam int PIN_PERR  = 3;
    localparam int PIN_SEL   = 4;
    localparam int PIN_LHI   = 5;

    // pending bit positions
    localparam int SRC_ACK   = 0;
    localparam int SRC_EPPTO = 1;
    localparam int SRC_FAULT = 2;
    localparam int SRC_BIN   = 3;
    localparam int SRC_BOUT  = 4;
    localparam int SRC_CHG   = 5;
    localparam int SRC_DISC  = 6;

    // snapshot bit positions for the level status fields
    localparam int SNAP_BIN_EMPTY  = 4;
    localparam int SNAP_BOUT_EMPTY = 5;

    typedef enum logic [1:0] {
        DT_IDLE  = 2'd0,
        DT_COUNT = 2'd1,
        DT_DONE  = 2'd2
    } dt_state_e;

endpackage

// File: rtl/pp_pin_sync.sv
module pp_pin_sync #(
    parameter int             W       = 6,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            // STAGES synchronizer flops plus one history flop
            logic [STAGES:0] sh;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh <= {(STAGES+1){RST_VAL[i]}};
                end else begin
                    sh <= {sh[STAGES-1:0], din[i]};
                end
            end

            assign lvl[i]  = sh[STAGES-1];
            assign rise[i] = sh[STAGES-1] & ~sh[STAGES];
            assign fall[i] = ~sh[STAGES-1] & sh[STAGES];
        end
    endgenerate

endmodule

// File: rtl/pp_dsc_timer.sv
module pp_dsc_timer
    import pp_irq_pkg::*;
#(
    parameter int LIMIT = 48_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    output logic fire
);

    localparam int             CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0]  LAST = CW'(LIMIT - 1);

    dt_state_e       state;
    dt_state_e       state_nx;
    logic [CW-1:0]   cnt;
    logic            at_last;

    assign at_last = (cnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DT_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: ARM, BREAK, EXPIRE, RELEASE
    always_comb begin
        state_nx = state;
        unique case (state)
            DT_IDLE: begin
                if (qual) state_nx = DT_COUNT;          // ARM
            end
            DT_COUNT: begin
                if (!qual)        state_nx = DT_IDLE;   // BREAK
                else if (at_last) state_nx = DT_DONE;   // EXPIRE
            end
            DT_DONE: begin
                if (!qual) state_nx = DT_IDLE;          // RELEASE
            end
            default: state_nx = DT_IDLE;
        endcase
    end

    // outputs and the cycle counter
    always_comb begin
        fire = 1'b0;
        unique case (state)
            DT_COUNT: fire = qual && at_last;
            DT_IDLE,
            DT_DONE:  fire = 1'b0;
            default:  fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == DT_COUNT && state_nx == DT_COUNT) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/pp_sticky_bank.sv
module pp_sticky_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] pend
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend[i] <= 1'b0;
                end else begin
                    // a same-cycle set wins over the read clear
                    pend[i] <= set[i] | (pend[i] & ~clr);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pp_irq_gather.sv
module pp_irq_gather
    import pp_irq_pkg::*;
#(
    parameter int                    SEC_CYCLES  = 48_000_000,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [NUM_PINS-1:0]   PIN_IDLE    = 6'b110101
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pin_ack_n,
    input  logic                 pin_busy,
    input  logic                 pin_fault_n,
    input  logic                 pin_perr,
    input  logic                 pin_sel,
    input  logic                 pin_logic_hi,
    input  logic                 ecp_mode,
    input  logic                 epp_timeout,
    input  logic                 bin_avail,
    input  logic                 bout_empty,
    input  logic                 ctl_ack_en,
    input  logic [NUM_SRC-2:0]   ctl_mask,
    input  logic                 rd_stb,
    output logic [NUM_SRC-1:0]   pend,
    output logic                 irq,
    output logic [SNAP_W-1:0]    snap
);

    logic [NUM_PINS-1:0] pins_raw;
    logic [NUM_PINS-1:0] pin_lvl;
    logic [NUM_PINS-1:0] pin_rise;
    logic [NUM_PINS-1:0] pin_fall;
    logic [NUM_SRC-1:0]  src_raw;
    logic [NUM_SRC-1:0]  src_en;
    logic [NUM_SRC-1:0]  src_set;
    logic                bout_prev;
    logic                dsc_qual;
    logic                dsc_fire;

    assign pins_raw[PIN_ACK]   = pin_ack_n;
    assign pins_raw[PIN_BUSY]  = pin_busy;
    assign pins_raw[PIN_FAULT] = pin_fault_n;
    assign pins_raw[PIN_PERR]  = pin_perr;
    assign pins_raw[PIN_SEL]   = pin_sel;
    assign pins_raw[PIN_LHI]   = pin_logic_hi;

    pp_pin_sync #(
        .W       (NUM_PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    // outbound pipeline history for its empty edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bout_prev <= 1'b0;
        end else begin
            bout_prev <= bout_empty;
        end
    end

    // detach timeout qualifier: logic-high low, all other lines high
    assign dsc_qual = ~pin_lvl[PIN_LHI] &
                      (&{pin_lvl[PIN_ACK], pin_lvl[PIN_BUSY], pin_lvl[PIN_FAULT],
                         pin_lvl[PIN_PERR], pin_lvl[PIN_SEL]});

    pp_dsc_timer #(
        .LIMIT(SEC_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .qual (dsc_qual),
        .fire (dsc_fire)
    );

    // raw condition sources
    always_comb begin
        src_raw            = '0;
        src_raw[SRC_ACK]   = pin_rise[PIN_ACK];
        src_raw[SRC_EPPTO] = epp_timeout;
        src_raw[SRC_FAULT] = ecp_mode & (pin_fall[PIN_FAULT] | ~pin_lvl[PIN_FAULT]);
        src_raw[SRC_BIN]   = bin_avail;
        src_raw[SRC_BOUT]  = bout_empty & ~bout_prev;
        src_raw[SRC_CHG]   = |(pin_rise | pin_fall);
        src_raw[SRC_DISC]  = pin_fall[PIN_LHI] | dsc_fire;
    end

    // enables: one active-high, the rest active-low masks
    generate
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_en
            if (k == SRC_ACK) begin : g_hi
                assign src_en[k] = ctl_ack_en;
            end else begin : g_lo
                assign src_en[k] = ~ctl_mask[k-1];
            end
        end
    endgenerate

    assign src_set = src_raw & src_en;

    pp_sticky_bank #(
        .N(NUM_SRC)
    ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (src_set),
        .clr  (rd_stb),
        .pend (pend)
    );

    assign irq = |(pend & src_en);

    // snapshot captured on the read strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (rd_stb) begin
            snap                  <= '0;
            snap[SRC_BIN:SRC_ACK] <= pend[SRC_BIN:SRC_ACK];
            snap[SNAP_BIN_EMPTY]  <= ~bin_avail;
            snap[SNAP_BOUT_EMPTY] <= bout_empty;
        end
    end

endmodule

// File: rtl/pp_irq_gather_chk.sv
module pp_irq_gather_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       ctl_ack_en,
    input logic [5:0] ctl_mask,
    input logic       ecp_mode,
    input logic       bin_avail,
    input logic       bout_empty,
    input logic [6:0] src_set,
    input logic [6:0] pend,
    input logic       irq,
    input logic [7:0] snap
);

    a_r2_ack_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_ack_en && !pend[0]) |=> !pend[0]);

    a_r13_eppto_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mask[0] && !pend[1]) |=> !pend[1]);

    a_r3_bin_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mask[2] && !pend[3]) |=> !pend[3]);

    a_r8_disc_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mask[5] && !pend[6]) |=> !pend[6]);

    a_r4_fault_ecp_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecp_mode && !pend[2]) |=> !pend[2]);

    a_r10_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (snap[3:0] == $past(pend[3:0])));

    a_r5_snap_bin_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (snap[4] == !$past(bin_avail)));

    a_r6_snap_bout_level: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (snap[5] == $past(bout_empty)));

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && src_set == 7'd0) |=> (pend == 7'd0));

    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((pend & $past(pend)) == $past(pend)));

    a_r11_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend != 7'd0));

endmodule

bind pp_irq_gather pp_irq_gather_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .ctl_ack_en(ctl_ack_en),
    .ctl_mask  (ctl_mask),
    .ecp_mode  (ecp_mode),
    .bin_avail (bin_avail),
    .bout_empty(bout_empty),
    .src_set   (src_set),
    .pend      (pend),
    .irq       (irq),
    .snap      (snap)
);

// File: tb/pp_irq_gather_test.sv
module pp_irq_gather_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  TICKS      = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] pins;       // [0]ack_n [1]busy [2]fault_n [3]perr [4]sel [5]logic_hi
    logic       ecp_mode, epp_timeout, bin_avail, bout_empty, ctl_ack_en, rd_stb;
    logic [5:0] ctl_mask;
    logic [6:0] pend;
    logic       irq;
    logic [7:0] snap;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pp_irq_gather #(.SEC_CYCLES(TICKS)) uut (
        .clk(clk), .rst_n(rst_n),
        .pin_ack_n(pins[0]), .pin_busy(pins[1]), .pin_fault_n(pins[2]),
        .pin_perr(pins[3]), .pin_sel(pins[4]), .pin_logic_hi(pins[5]),
        .ecp_mode(ecp_mode), .epp_timeout(epp_timeout),
        .bin_avail(bin_avail), .bout_empty(bout_empty),
        .ctl_ack_en(ctl_ack_en), .ctl_mask(ctl_mask), .rd_stb(rd_stb),
        .pend(pend), .irq(irq), .snap(snap)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        tick(1);
        rd_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [6:0] exp;
        pins        = 6'b110101;
        ecp_mode    = 1'b1;
        epp_timeout = 1'b0;
        bin_avail   = 1'b0;
        bout_empty  = 1'b0;
        ctl_ack_en  = 1'b1;
        ctl_mask    = 6'b0;
        rd_stb      = 1'b0;
        rst_n       = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1
        check(pend == 7'd0, "R1 pend", pend, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(snap == 8'd0, "R1 snap", snap, 0);

        // R2 R3 R11 R10: sweep every enable/mask combination
        for (int cfg = 0; cfg < 128; cfg++) begin
            ctl_ack_en = cfg[0];
            ctl_mask   = cfg[6:1];
            tick(2);
            do_read();
            check(pend == 7'd0, "R10 clear before sweep step", pend, 0);
            pins[0] = 1'b0; tick(1);
            pins[0] = 1'b1; epp_timeout = 1'b1; tick(1);
            epp_timeout = 1'b0; pins[2] = 1'b0; tick(1);
            pins[2] = 1'b1; pins[5] = 1'b0; tick(1);
            pins[5] = 1'b1; bin_avail = 1'b1; tick(1);
            bin_avail = 1'b0; bout_empty = 1'b1; tick(1);
            bout_empty = 1'b0; tick(6);
            exp = {~ctl_mask, ctl_ack_en};
            check(pend == exp, "R2/R3 sweep pend", pend, exp);
            check(irq == (exp != 0), "R11 sweep irq", irq, (exp != 0));
            do_read();
            check(snap == {2'b01, exp[3:0]}, "R10 sweep snap", snap, {2'b01, exp[3:0]});
            check(pend == 7'd0, "R10 sweep clear", pend, 0);
        end

        ctl_ack_en = 1'b1;
        ctl_mask   = 6'b0;

        // R4: fault watched only in ecp mode, level keeps refiring
        ecp_mode = 1'b0;
        tick(2); do_read();
        pins[2] = 1'b0; tick(6);
        check(pend[2] == 1'b0, "R4 fault outside ecp", pend[2], 0);
        ecp_mode = 1'b1; tick(2);
        check(pend[2] == 1'b1, "R4 fault low level", pend[2], 1);
        do_read();
        check(pend[2] == 1'b1, "R4 fault level refires", pend[2], 1);
        pins[2] = 1'b1; tick(6); do_read();
        check(pend == 7'd0, "R4 quiet after release", pend, 0);

        // R5: inbound level
        bin_avail = 1'b1; tick(2); do_read();
        check(pend[3] == 1'b1, "R5 bin level refires", pend[3], 1);
        check(snap[4] == 1'b0, "R5 bin empty flag", snap[4], 0);
        bin_avail = 1'b0; tick(1); do_read();
        check(pend[3] == 1'b0, "R5 bin gone", pend[3], 0);

        // R6: outbound edge only
        bout_empty = 1'b1; tick(2);
        check(pend[4] == 1'b1, "R6 bout edge", pend[4], 1);
        do_read(); tick(2);
        check(pend[4] == 1'b0, "R6 bout no refire", pend[4], 0);
        do_read();
        check(snap[5] == 1'b1, "R6 bout level flag", snap[5], 1);
        bout_empty = 1'b0; tick(2); do_read();

        // R10 + R13: event in the read cycle survives
        epp_timeout = 1'b1; rd_stb = 1'b1; tick(1);
        epp_timeout = 1'b0; rd_stb = 1'b0;
        check(pend[1] == 1'b1, "R13/R10 same-cycle event kept", pend[1], 1);
        check(snap[1] == 1'b0, "R10 snap before event", snap[1], 0);

        // R12 sticky, R11 drop
        tick(20);
        check(pend[1] == 1'b1, "R12 sticky", pend[1], 1);
        check(irq == 1'b1, "R11 irq held", irq, 1);
        do_read();
        check(irq == 1'b0, "R11 irq drops", irq, 0);

        // R7: every line raises the change condition
        for (int i = 0; i < 6; i++) begin
            pins[i] = ~pins[i]; tick(5);
            check(pend[5] == 1'b1, "R7 line change", i, 1);
            do_read();
            pins[i] = ~pins[i]; tick(5);
            do_read();
        end

        // R8: logic-high falling edge, only detach enabled
        ctl_ack_en = 1'b0;
        ctl_mask   = 6'b011111;
        pins[5] = 1'b0; tick(5);
        check(pend == 7'b1000000, "R8 logic-high fall", pend, 7'b1000000);
        pins[5] = 1'b1; tick(5); do_read();

        // R9: one-second timeout, once, restart on break
        pins[1] = 1'b1; pins[3] = 1'b1; tick(5); do_read();
        pins[5] = 1'b0; tick(4); do_read();
        tick(TICKS - 12);
        check(pend[6] == 1'b0, "R9 not before limit", pend[6], 0);
        tick(14);
        check(pend[6] == 1'b1, "R9 timeout fires", pend[6], 1);
        do_read(); tick(2 * TICKS);
        check(pend[6] == 1'b0, "R9 fires once", pend[6], 0);
        pins[5] = 1'b1; tick(5); do_read();
        pins[5] = 1'b0; tick(4); do_read();
        tick(TICKS - 12);
        pins[1] = 1'b0; tick(4);
        pins[1] = 1'b1;
        tick(TICKS - 6);
        check(pend[6] == 1'b0, "R9 restart after break", pend[6], 0);
        tick(14);
        check(pend[6] == 1'b1, "R9 fires after restart", pend[6], 1);

        finish_run();
    end

endmodule